// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This block lets the cores of a small cluster (two to four cores by default) raise software interrupts on one another. Each core has its own command port. A command carries a code and a core-index argument. One readback register is shared by all cores and returns the result of the most recent query. There is one interrupt line per core.

For every target core the block keeps a vector that records which cores have sent it an interrupt that is not yet acknowledged. Several sends to the same target before it acknowledges merge into one asserted line. The target can query its sender vector, which may then hold several bits. It clears each sender separately with an acknowledge command.

Commands from different cores can arrive in the same cycle. A fixed-priority arbiter accepts one command per cycle, the lowest core index first, and holds the others off through their ready signals.

Top module: `icsu_top`

## Requirements
- R1: After reset all pending state is clear, every `irq` bit is 0 and `readback` is 0.
- R2: A generate command (code 4'h1) accepted from core S with argument T, where T differs from S, sets sender bit S in target T's vector. `irq[T]` is 1 from the cycle after acceptance.
- R3: A generate command whose argument equals the issuing core sets no pending state and leaves `irq` unchanged.
- R4: A status command (code 4'h2) with argument T loads `readback` with 1 if target T has any sender bit set, and with 0 otherwise. All upper bits are 0.
- R5: A source command (code 4'h3) loads `readback` with the issuer's sender vector, where bit i stands for core i (a single sender i gives the value 1<<i).
- R6: Interrupts sent to one target by several cores before it acknowledges produce a single asserted line. The sender vector shows every sender.
- R7: An acknowledge command (code 4'h4) with argument S clears only sender bit S in the issuer's vector. `irq` of the issuer drops in the cycle after its last bit is cleared. Acknowledging a bit that is not set changes nothing.
- R8: `readback` keeps the result of the latest status or source command. Generate and acknowledge commands do not change it.
- R9: When several cores assert `cmd_valid` in one cycle, only the lowest-index one sees `cmd_ready` high. Only its command takes effect in that cycle, and the others are accepted in later cycles while they stay valid.
- R10: Any other command code is accepted and ignored, leaving the pending state, `irq` and `readback` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | N | Per-core command request |
| cmd_code | input | N*4 | Per-core command code, core i in bits [4i+3:4i] |
| cmd_arg | input | N*clog2(N) | Per-core core-index argument |
| cmd_ready | output | N | Per-core acceptance, combinational from `cmd_valid` |
| irq | output | N | Per-core interrupt line, OR of that core's sender vector |
| readback | output | N | Shared result register of the latest query |

## Verification
`cmd_ready` is combinational, so the bench reads it shortly after driving `cmd_valid`, before the clock edge that accepts the command. The pending vectors and the readback register each sit one register stage behind acceptance. `irq` is the OR of the registered vectors, so all three results are due exactly one edge after the accepting edge. The bench drives each command on a falling edge and samples results on the next falling edge. For contention it steps one cycle at a time and checks the partial result after each accepting edge.

// File: rtl/icsu_pkg.sv
package icsu_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_GEN    = 4'h1,
        OP_STATUS = 4'h2,
        OP_SOURCE = 4'h3,
        OP_ACK    = 4'h4
    } icsu_op_e;
endpackage

// File: rtl/icsu_arbiter.sv
module icsu_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt = N'(1) << i;
        end
    end

    // R9
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R9
    gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/icsu_matrix.sv
module icsu_matrix #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IW-1:0]       set_tgt,
    input  logic [IW-1:0]       set_src,
    input  logic                clr_en,
    input  logic [IW-1:0]       clr_tgt,
    input  logic [IW-1:0]       clr_src,
    output logic [N-1:0][N-1:0] pend_q
);
    typedef struct packed {
        logic [N-1:0][N-1:0] pend;
    } mtx_state_t;

    mtx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) st_d.pend[clr_tgt][clr_src] = 1'b0;
        // a same-cycle set wins over a clear so no interrupt is lost
        if (set_en) st_d.pend[set_tgt][set_src] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> pend_q[$past(set_tgt)][$past(set_src)]);
    // R7
    clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> !pend_q[$past(clr_tgt)][$past(clr_src)]);

    for (genvar g = 0; g < N; g++) begin : g_diag
        // R3
        no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pend_q[g][g]);
    end
endmodule

// File: rtl/icsu_top.sv
module icsu_top
    import icsu_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        cmd_valid,
    input  logic [N*CODE_W-1:0] cmd_code,
    input  logic [N*IW-1:0]     cmd_arg,
    output logic [N-1:0]        cmd_ready,
    output logic [N-1:0]        irq,
    output logic [N-1:0]        readback
);
    typedef struct packed {
        logic [N-1:0] rb;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [N-1:0]        gnt;
    logic                acc;
    logic [IW-1:0]       issuer;
    logic [CODE_W-1:0]   code;
    logic [IW-1:0]       arg;
    logic                do_gen, do_ack, is_query;
    logic [N-1:0][N-1:0] pend;

    icsu_arbiter #(.N(N)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (cmd_valid),
        .gnt   (gnt)
    );

    always_comb begin
        issuer = '0;
        code   = '0;
        arg    = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) begin
                issuer = IW'(i);
                code   = cmd_code[i*CODE_W +: CODE_W];
                arg    = cmd_arg[i*IW +: IW];
            end
        end
    end

    assign acc      = |gnt;
    assign do_gen   = acc && (code == OP_GEN) && (arg != issuer);
    assign do_ack   = acc && (code == OP_ACK);
    assign is_query = acc && ((code == OP_STATUS) || (code == OP_SOURCE));

    icsu_matrix #(.N(N), .IW(IW)) u_mtx (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (do_gen),
        .set_tgt (arg),
        .set_src (issuer),
        .clr_en  (do_ack),
        .clr_tgt (issuer),
        .clr_src (arg),
        .pend_q  (pend)
    );

    always_comb begin
        st_d = st_q;
        if (acc && code == OP_STATUS) st_d.rb = N'(|pend[arg]);
        else if (acc && code == OP_SOURCE) st_d.rb = pend[issuer];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int t = 0; t < N; t++) irq[t] = |pend[t];
    end

    assign cmd_ready = gnt;
    assign readback  = st_q.rb;

    // R8
    rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_query |=> $stable(readback));
    // R7
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0 && !do_ack) |=> (($past(irq) & ~irq) == '0));
endmodule

// File: tb/sim_icsu_top.sv
module sim_icsu_top;
    localparam int N  = 4;
    localparam int IW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   cmd_valid = '0;
    logic [N*4-1:0] cmd_code = '0;
    logic [N*IW-1:0] cmd_arg = '0;
    logic [N-1:0]   cmd_ready, irq, readback;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    icsu_top #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .irq(irq), .readback(readback)
    );

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic issue(int core, logic [3:0] code, int arg);
        @(negedge clk);
        cmd_valid[core] = 1'b1;
        cmd_code[core*4 +: 4] = code;
        cmd_arg[core*IW +: IW] = IW'(arg);
        @(negedge clk);
        cmd_valid = '0;
    endtask

    task automatic t_reset;
        check("R1 irq", irq, 4'b0000);
        check("R1 readback", readback, 4'b0000);
        check("R9 idle ready", cmd_ready, 4'b0000);
    endtask

    task automatic t_single;
        issue(1, 4'h1, 2);
        check("R2 irq", irq, 4'b0100);
        issue(2, 4'h3, 0);
        check("R5 source", readback, 4'b0010);
        issue(0, 4'h2, 2);
        check("R4 status set", readback, 4'b0001);
        issue(0, 4'h2, 3);
        check("R4 status clear", readback, 4'b0000);
    endtask

    task automatic t_self;
        issue(3, 4'h1, 3);
        check("R3 irq", irq, 4'b0100);
        issue(3, 4'h3, 0);
        check("R3 vector", readback, 4'b0000);
    endtask

    task automatic t_merge;
        issue(0, 4'h1, 2);
        issue(3, 4'h1, 2);
        check("R6 irq", irq, 4'b0100);
        issue(2, 4'h3, 0);
        check("R6 vector", readback, 4'b1011);
    endtask

    task automatic t_ack;
        issue(2, 4'h4, 0);
        check("R7 irq held", irq, 4'b0100);
        issue(2, 4'h3, 0);
        check("R7 one bit", readback, 4'b1010);
        issue(2, 4'h4, 0);
        issue(2, 4'h3, 0);
        check("R7 no-op ack", readback, 4'b1010);
        issue(2, 4'h4, 1);
        check("R7 irq held2", irq, 4'b0100);
        issue(2, 4'h4, 3);
        check("R7 irq drop", irq, 4'b0000);
    endtask

    task automatic t_hold;
        issue(1, 4'h2, 1);
        check("R8 setup", readback, 4'b0000);
        issue(0, 4'h1, 3);
        check("R8 after gen", readback, 4'b0000);
        issue(3, 4'h3, 0);
        check("R8 source", readback, 4'b0001);
        issue(3, 4'h4, 0);
        check("R8 after ack", readback, 4'b0001);
        check("R8 irq", irq, 4'b0000);
    endtask

    task automatic t_unknown;
        issue(0, 4'h1, 1);
        issue(2, 4'h3, 0);
        issue(1, 4'hF, 0);
        issue(1, 4'h0, 0);
        check("R10 irq", irq, 4'b0010);
        check("R10 readback", readback, 4'b0000);
        issue(1, 4'h4, 0);
    endtask

    task automatic t_arb;
        @(negedge clk);
        cmd_valid = 4'b0101;
        cmd_code = {4'h0, 4'h1, 4'h0, 4'h1};
        cmd_arg = {2'd0, 2'd3, 2'd0, 2'd1};
        #1;
        check("R9 ready pair", cmd_ready, 4'b0001);
        @(negedge clk);
        check("R9 first only", irq, 4'b0010);
        cmd_valid[0] = 1'b0;
        #1;
        check("R9 ready next", cmd_ready, 4'b0100);
        @(negedge clk);
        cmd_valid = '0;
        check("R9 second", irq, 4'b1010);
        issue(1, 4'h4, 0);
        issue(3, 4'h4, 2);
        check("R9 cleanup", irq, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_single;
        t_self;
        t_merge;
        t_ack;
        t_hold;
        t_unknown;
        t_arb;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule